// File: doc/BRIEF.md
# Egress descriptor ring consumer

This block drains a circular ring of two-word transmit descriptors that software fills in memory. It reads one ring slot at a time through a synchronous read port. A generation bit in each slot decides whether the slot holds a fresh descriptor. Each accepted descriptor becomes a series of per-buffer transfer commands for a downstream packet mover and, when the descriptor asks for it, buffer-release commands for a buffer manager. Data movement, checksum arithmetic and the buffer manager are outside the block.

Software advances a tail count, made of the slot index plus a wrap bit, to tell the consumer that slots are waiting. The consumer keeps its own count and reads the slot at that count. It checks the slot's generation bit against the expected value, which flips on every ring wrap. A stale slot is left in place and read again later.

A descriptor either names one unchained buffer or a chain of equally sized buffers. A chain is walked from a start offset, and each buffer in it becomes one command. Descriptors with no length, or with reserved bits set, move no data. Drop descriptors move no data but still return their buffers. A notification pulse marks the end of a packet whose descriptors requested one.

Top module: `egr_desc_consumer`

## Requirements
- R1: While reset is held and right after it, xc_valid, rel_valid, rd_en, notif_pulse and desc_err are all low.
- R2: A ring read is started only while tail_cnt (slot index plus wrap bit, IDX_W+1 bits) differs from the consumer's own count. The read address is the low IDX_W bits of that count, and data returns one cycle later. Word 0 sits in rd_data[63:0] and word 1 in rd_data[127:64].
- R3: The generation bit is word 0 bit 0. It must be 1 while the consumer's wrap bit is 0 and 0 while the wrap bit is 1. On a mismatch nothing is issued, the count stays, and the slot is read again.
- R4: If word 1 bits 63:62 are both zero, the descriptor is unchained and gives one transfer. Its address is word 1 bits 41:0 sign-extended to 64 bits, and its length is word 0 bits 29:16.
- R5: If word 1 bits 63:62 are non-zero, the descriptor is chained. The buffer size comes from code word 1 bits 61:59, with codes 0..7 giving 128, 256, 512, 1024, 1664, 4096, 10368 and 16384 bytes. The first transfer runs from the address to the end of its buffer, whose base is the address with bits 6:0 cleared. Each later transfer starts at the previous base plus the buffer size. The transfers continue until the length is used up, and the next slot is read only after that.
- R6: The boundary flag is word 0 bit 11. When it is set, xc_eop is high on the descriptor's last transfer and on no other transfer.
- R7: A descriptor with length zero issues neither a transfer nor a release.
- R8: The drop flag is word 0 bit 9. A drop descriptor issues no transfer. It still issues, one per cycle, the releases that R9 would give for the same buffers.
- R9: When word 1 bit 58 is set, each buffer gets one release. The release carries the buffer base (the address itself if the descriptor is unchained), the stack index from word 1 bits 52:48 and the owner bit from word 1 bit 56. For data descriptors the release comes in the cycle of the transfer handshake. When bit 58 is clear, no release is issued.
- R10: The notify flag is word 0 bit 10. It may be set on any descriptor of a packet. Exactly one one-cycle notif_pulse follows the retirement of the packet's boundary descriptor, and none follows if no descriptor of the packet set the flag.
- R11: Any of the reserved bits (word 0 bits 7:1, 15:12, 31:30; word 1 bits 47:42, 55:53, 57) set causes a one-cycle desc_err pulse. The descriptor is then handled as in R7, but its boundary and notify flags still count.
- R12: While xc_valid is high and xc_ready is low, xc_valid stays high and the command fields stay unchanged.
- R13: The checksum fields travel with the transfers. The enable is word 0 bit 8, the destination bits 39:32, the start bits 47:40 and the seed bits 63:48. xc_first marks a descriptor's first transfer, and xc_csum_en is high only on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tail_cnt | input | IDX_W+1 | Producer count: slot index plus wrap bit |
| rd_en | output | 1 | Ring read strobe |
| rd_addr | output | IDX_W | Ring slot to read |
| rd_data | input | 128 | Slot contents, valid one cycle after rd_en |
| xc_valid | output | 1 | Transfer command valid |
| xc_ready | input | 1 | Packet mover accepts command |
| xc_addr | output | 64 | Transfer start address |
| xc_len | output | 14 | Transfer length in bytes |
| xc_eop | output | 1 | Last transfer of the packet |
| xc_first | output | 1 | First transfer of the descriptor |
| xc_csum_en | output | 1 | Checksum requested (first transfer only) |
| xc_csum_start | output | 8 | Checksum start byte |
| xc_csum_dest | output | 8 | Checksum destination byte |
| xc_csum_seed | output | 16 | Checksum seed |
| rel_valid | output | 1 | Buffer release command |
| rel_addr | output | 64 | Buffer base address to release |
| rel_stack | output | 5 | Target buffer stack |
| rel_owner | output | 1 | Owning instance of the buffer |
| notif_pulse | output | 1 | Packet-sent notification |
| desc_err | output | 1 | Malformed descriptor seen |

## Verification
The chain walk is swept over every buffer size code with start offsets of 0, 5 and 127 and with lengths of one byte, exactly the first buffer's room, one byte past it, and several buffers. This separates an off-by-one in the room arithmetic from a wrong base step or wrong size entry. The same sweep runs with a pseudo-random ready pattern and wraps the small ring many times, so the generation flip is used on every pass. Single cases then cover the zero-length, drop, no-release, reserved-bit, multi-descriptor-packet and stale-generation descriptors. Each of these differs from a normal descriptor in exactly one flag, so the output it suppresses or keeps points to one decode path.

// File: rtl/egr_desc_pkg.sv
package egr_desc_pkg;
  localparam int VA_W   = 42;
  localparam int LEN_W  = 14;
  localparam int ADDR_W = 64;
  localparam int STK_W  = 5;
  localparam int SZC_W  = 3;
  localparam int OFS_W  = 7;
  localparam int BSZ_W  = LEN_W + 1;
  localparam int DESC_W = 128;

  // Decoded slot contents.
  typedef struct packed {
    logic              gen;
    logic              csum;
    logic              nosend;
    logic              notif;
    logic              bound;
    logic [LEN_W-1:0]  len;
    logic [7:0]        cdest;
    logic [7:0]        cstart;
    logic [15:0]       seed;
    logic [ADDR_W-1:0] addr;
    logic [STK_W-1:0]  stack;
    logic              owner;
    logic              hwb;
    logic [SZC_W-1:0]  szc;
    logic              chained;
  } desc_t;

  // Working context of the descriptor in flight.
  typedef struct packed {
    logic              csum;
    logic              bound;
    logic [LEN_W-1:0]  len;
    logic [7:0]        cdest;
    logic [7:0]        cstart;
    logic [15:0]       seed;
    logic [ADDR_W-1:0] addr;
    logic [STK_W-1:0]  stack;
    logic              owner;
    logic              hwb;
    logic [SZC_W-1:0]  szc;
    logic              chained;
  } ctx_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEC  = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } cstate_t;

  function automatic logic [BSZ_W-1:0] buf_bytes(input logic [SZC_W-1:0] code);
    case (code)
      3'd0:    return 15'd128;
      3'd1:    return 15'd256;
      3'd2:    return 15'd512;
      3'd3:    return 15'd1024;
      3'd4:    return 15'd1664;
      3'd5:    return 15'd4096;
      3'd6:    return 15'd10368;
      default: return 15'd16384;
    endcase
  endfunction
endpackage

// File: rtl/egr_desc_unpack.sv
module egr_desc_unpack
  import egr_desc_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output desc_t             dsc,
  output logic              rsvd_bad
);
  logic [63:0] w0;
  logic [63:0] w1;

  assign w0 = raw[63:0];
  assign w1 = raw[127:64];

  always_comb begin
    dsc.gen     = w0[0];
    dsc.csum    = w0[8];
    dsc.nosend  = w0[9];
    dsc.notif   = w0[10];
    dsc.bound   = w0[11];
    dsc.len     = w0[29:16];
    dsc.cdest   = w0[39:32];
    dsc.cstart  = w0[47:40];
    dsc.seed    = w0[63:48];
    dsc.addr    = {{(ADDR_W-VA_W){w1[VA_W-1]}}, w1[VA_W-1:0]};
    dsc.stack   = w1[52:48];
    dsc.owner   = w1[56];
    dsc.hwb     = w1[58];
    dsc.szc     = w1[61:59];
    dsc.chained = |w1[63:62];
  end

  assign rsvd_bad = |{w0[7:1], w0[15:12], w0[31:30],
                      w1[47:42], w1[55:53], w1[57]};
endmodule

// File: rtl/egr_ring_ptr.sv
module egr_ring_ptr #(
  parameter int IDX_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [IDX_W:0] head_cnt,
  output logic         exp_gen
);
  logic [IDX_W:0] cnt_q;
  logic [IDX_W:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_n;
    end
  end

  assign head_cnt = cnt_q;
  // Software writes 1 on the first pass; the expected value flips per wrap.
  assign exp_gen  = ~cnt_q[IDX_W];
endmodule

// File: rtl/egr_chunk_calc.sv
module egr_chunk_calc
  import egr_desc_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic              chained,
  input  logic [SZC_W-1:0]  szc,
  output logic [LEN_W-1:0]  chunk_len,
  output logic [ADDR_W-1:0] buf_base,
  output logic [ADDR_W-1:0] next_addr,
  output logic              is_last
);
  logic [BSZ_W-1:0] bsz;
  logic [BSZ_W-1:0] room;
  logic             fits;

  always_comb begin
    bsz       = buf_bytes(szc);
    room      = bsz - {{(BSZ_W-OFS_W){1'b0}}, cur_addr[OFS_W-1:0]};
    fits      = ({1'b0, remain} <= room);
    chunk_len = (!chained || fits) ? remain : room[LEN_W-1:0];
    buf_base  = chained ? {cur_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}} : cur_addr;
    next_addr = buf_base + {{(ADDR_W-BSZ_W){1'b0}}, bsz};
    is_last   = (chunk_len == remain);
  end
endmodule

// File: rtl/egr_desc_consumer.sv
module egr_desc_consumer
  import egr_desc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W:0]    tail_cnt,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [DESC_W-1:0] rd_data,
  output logic              xc_valid,
  input  logic              xc_ready,
  output logic [ADDR_W-1:0] xc_addr,
  output logic [LEN_W-1:0]  xc_len,
  output logic              xc_eop,
  output logic              xc_first,
  output logic              xc_csum_en,
  output logic [7:0]        xc_csum_start,
  output logic [7:0]        xc_csum_dest,
  output logic [15:0]       xc_csum_seed,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [STK_W-1:0]  rel_stack,
  output logic              rel_owner,
  output logic              notif_pulse,
  output logic              desc_err
);
  cstate_t st_q, st_n;
  ctx_t    ctx_q, ctx_n;
  logic    first_q, first_n;
  logic    pend_q, pend_n;
  logic    notif_q, notif_n;
  logic    err_q, err_n;

  logic             adv;
  logic             step;
  logic             ctx_en;
  logic             nodata;
  logic             pend_sum;
  logic [IDX_W:0]   head_cnt;
  logic             exp_gen;
  desc_t            dsc;
  logic             rsvd_bad;
  logic [LEN_W-1:0] chunk_len;
  logic [ADDR_W-1:0] buf_base;
  logic [ADDR_W-1:0] next_addr;
  logic             is_last;

  egr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .head_cnt (head_cnt),
    .exp_gen  (exp_gen)
  );

  egr_desc_unpack u_unpack (
    .raw      (rd_data),
    .dsc      (dsc),
    .rsvd_bad (rsvd_bad)
  );

  egr_chunk_calc u_chunk (
    .cur_addr  (ctx_q.addr),
    .remain    (ctx_q.len),
    .chained   (ctx_q.chained),
    .szc       (ctx_q.szc),
    .chunk_len (chunk_len),
    .buf_base  (buf_base),
    .next_addr (next_addr),
    .is_last   (is_last)
  );

  // Next-state logic.
  always_comb begin
    st_n     = st_q;
    ctx_n    = ctx_q;
    first_n  = first_q;
    pend_n   = pend_q;
    notif_n  = 1'b0;
    err_n    = 1'b0;
    adv      = 1'b0;
    step     = 1'b0;
    rd_en    = 1'b0;
    xc_valid = 1'b0;
    rel_valid = 1'b0;
    nodata   = rsvd_bad | (dsc.len == '0);
    pend_sum = pend_q | dsc.notif;

    case (st_q)
      ST_IDLE: begin
        if (tail_cnt != head_cnt) begin
          rd_en = 1'b1;
          st_n  = ST_DEC;
        end
      end
      ST_DEC: begin
        st_n = ST_IDLE;
        if (dsc.gen == exp_gen) begin
          adv           = 1'b1;
          first_n       = 1'b1;
          err_n         = rsvd_bad;
          ctx_n.csum    = dsc.csum;
          ctx_n.bound   = dsc.bound;
          ctx_n.len     = dsc.len;
          ctx_n.cdest   = dsc.cdest;
          ctx_n.cstart  = dsc.cstart;
          ctx_n.seed    = dsc.seed;
          ctx_n.addr    = dsc.addr;
          ctx_n.stack   = dsc.stack;
          ctx_n.owner   = dsc.owner;
          ctx_n.hwb     = dsc.hwb;
          ctx_n.szc     = dsc.szc;
          ctx_n.chained = dsc.chained;
          if (nodata || (dsc.nosend && !dsc.hwb)) begin
            if (dsc.bound) begin
              notif_n = pend_sum;
              pend_n  = 1'b0;
            end else begin
              pend_n  = pend_sum;
            end
          end else begin
            pend_n = pend_sum;
            st_n   = dsc.nosend ? ST_REL : ST_XFER;
          end
        end
      end
      ST_XFER: begin
        xc_valid = 1'b1;
        if (xc_ready) begin
          rel_valid = ctx_q.hwb;
          step      = 1'b1;
        end
      end
      ST_REL: begin
        rel_valid = 1'b1;
        step      = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase

    if (step) begin
      ctx_n.addr = next_addr;
      ctx_n.len  = ctx_q.len - chunk_len;
      first_n    = 1'b0;
      if (is_last) begin
        st_n = ST_IDLE;
        if (ctx_q.bound) begin
          notif_n = pend_q;
          pend_n  = 1'b0;
        end
      end
    end
  end

  assign ctx_en = adv | step;

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
      notif_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      first_q <= first_n;
      pend_q  <= pend_n;
      notif_q <= notif_n;
      err_q   <= err_n;
    end
  end

  // Descriptor context, data path only.
  always_ff @(posedge clk) begin
    if (ctx_en) begin
      ctx_q <= ctx_n;
    end
  end

  assign rd_addr       = head_cnt[IDX_W-1:0];
  assign xc_addr       = ctx_q.addr;
  assign xc_len        = chunk_len;
  assign xc_eop        = ctx_q.bound & is_last;
  assign xc_first      = first_q;
  assign xc_csum_en    = ctx_q.csum & first_q;
  assign xc_csum_start = ctx_q.cstart;
  assign xc_csum_dest  = ctx_q.cdest;
  assign xc_csum_seed  = ctx_q.seed;
  assign rel_addr      = buf_base;
  assign rel_stack     = ctx_q.stack;
  assign rel_owner     = ctx_q.owner;
  assign notif_pulse   = notif_q;
  assign desc_err      = err_q;
endmodule

// File: rtl/egr_desc_consumer_chk.sv
module egr_desc_consumer_chk #(
  parameter int IDX_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        xc_valid,
  input logic        xc_ready,
  input logic [63:0] xc_addr,
  input logic [13:0] xc_len,
  input logic        xc_eop,
  input logic        rel_valid,
  input logic        notif_pulse,
  input logic        desc_err
);
  AST_XC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xc_valid && !xc_ready) |=> (xc_valid && $stable(xc_addr) && $stable(xc_len) && $stable(xc_eop))); // R12

  AST_REL_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && xc_valid) |-> xc_ready); // R9

  AST_NO_FETCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (xc_valid || rel_valid) |-> !rd_en); // R2

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xc_valid |-> (xc_len != 14'd0)); // R7

  AST_NOTIF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    notif_pulse |=> !notif_pulse); // R10

  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> !xc_valid); // R11
endmodule

bind egr_desc_consumer egr_desc_consumer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .xc_valid    (xc_valid),
  .xc_ready    (xc_ready),
  .xc_addr     (xc_addr),
  .xc_len      (xc_len),
  .xc_eop      (xc_eop),
  .rel_valid   (rel_valid),
  .notif_pulse (notif_pulse),
  .desc_err    (desc_err)
);

// File: tb/egr_desc_consumer_tb_top.sv
`timescale 1ns/1ps
module egr_desc_consumer_tb_top;
  localparam int DEPTH = 4;
  localparam int IDX_W = 2;
  localparam int LOGN  = 512;

  typedef struct {
    logic        csum;
    logic        ns;
    logic        notif;
    logic        bound;
    int          len;
    logic [7:0]  cdest;
    logic [7:0]  cstart;
    logic [15:0] seed;
    logic [41:0] va;
    logic [4:0]  stk;
    logic        owner;
    logic        hwb;
    logic [2:0]  szc;
    logic [1:0]  c;
    int          rsvd;
  } tdesc_t;

  logic          clk;
  logic          rst_n;
  logic [IDX_W:0] tail_cnt;
  logic          rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic [127:0]  rd_data;
  logic          xc_valid;
  logic          xc_ready;
  logic [63:0]   xc_addr;
  logic [13:0]   xc_len;
  logic          xc_eop;
  logic          xc_first;
  logic          xc_csum_en;
  logic [7:0]    xc_csum_start;
  logic [7:0]    xc_csum_dest;
  logic [15:0]   xc_csum_seed;
  logic          rel_valid;
  logic [63:0]   rel_addr;
  logic [4:0]    rel_stack;
  logic          rel_owner;
  logic          notif_pulse;
  logic          desc_err;

  logic [127:0]  mem [DEPTH];
  logic [7:0]    lfsr;
  logic          ready_rand;

  int n_chk;
  int n_err;
  int cyc;
  logic [IDX_W:0] prod;
  logic pend_m;

  // observation logs
  int nx, nr, nn, ne, nrd;
  logic [80:0] lx [LOGN];
  logic [69:0] lr [LOGN];
  logic [31:0] lcs;
  // expectation logs
  int enx, enr, enn, ene;
  logic [80:0] ex [LOGN];
  logic [69:0] er [LOGN];

  egr_desc_consumer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tail_cnt(tail_cnt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .xc_valid(xc_valid), .xc_ready(xc_ready), .xc_addr(xc_addr),
    .xc_len(xc_len), .xc_eop(xc_eop), .xc_first(xc_first),
    .xc_csum_en(xc_csum_en), .xc_csum_start(xc_csum_start),
    .xc_csum_dest(xc_csum_dest), .xc_csum_seed(xc_csum_seed),
    .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_stack(rel_stack),
    .rel_owner(rel_owner), .notif_pulse(notif_pulse), .desc_err(desc_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 8'hA5;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign xc_ready = ready_rand ? lfsr[0] : 1'b1;

  always @(negedge clk) begin
    if (rd_en) nrd = nrd + 1;
    if (xc_valid && xc_ready) begin
      if (nx < LOGN) lx[nx] = {xc_addr, xc_len, xc_eop, xc_csum_en, xc_first};
      if (nx == 0) lcs = {xc_csum_dest, xc_csum_start, xc_csum_seed};
      nx = nx + 1;
    end
    if (rel_valid) begin
      if (nr < LOGN) lr[nr] = {rel_addr, rel_stack, rel_owner};
      nr = nr + 1;
    end
    if (notif_pulse) nn = nn + 1;
    if (desc_err) ne = ne + 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int bsz_of(input logic [2:0] code);
    case (code)
      3'd0: return 128;
      3'd1: return 256;
      3'd2: return 512;
      3'd3: return 1024;
      3'd4: return 1664;
      3'd5: return 4096;
      3'd6: return 10368;
      default: return 16384;
    endcase
  endfunction

  function automatic logic [127:0] pack(input tdesc_t t, input logic gen);
    logic [63:0] w0;
    logic [63:0] w1;
    logic [127:0] r;
    w0 = '0; w1 = '0;
    w0[0] = gen; w0[8] = t.csum; w0[9] = t.ns; w0[10] = t.notif; w0[11] = t.bound;
    w0[29:16] = t.len[13:0]; w0[39:32] = t.cdest; w0[47:40] = t.cstart; w0[63:48] = t.seed;
    w1[41:0] = t.va; w1[52:48] = t.stk; w1[56] = t.owner; w1[58] = t.hwb;
    w1[61:59] = t.szc; w1[63:62] = t.c;
    r = {w1, w0};
    if (t.rsvd >= 0) r[t.rsvd] = 1'b1;
    return r;
  endfunction

  function automatic tdesc_t base_desc();
    tdesc_t t;
    t.csum = 0; t.ns = 0; t.notif = 0; t.bound = 1; t.len = 100;
    t.cdest = 8'h12; t.cstart = 8'h0E; t.seed = 16'hBEEF;
    t.va = 42'h2AB_CDE0_0000; t.stk = 5'd9; t.owner = 1'b1; t.hwb = 1'b1;
    t.szc = 3'd0; t.c = 2'd0; t.rsvd = -1;
    return t;
  endfunction

  task automatic clear_logs();
    nx = 0; nr = 0; nn = 0; ne = 0; nrd = 0;
    enx = 0; enr = 0; enn = 0; ene = 0;
  endtask

  task automatic model(input tdesc_t t);
    logic [63:0] a;
    logic [63:0] b;
    int rem;
    int ch;
    int room;
    int bs;
    bit first;
    if (t.len == 0 || t.rsvd >= 0) begin
      if (t.rsvd >= 0) ene = ene + 1;
    end else begin
      a = {{22{t.va[41]}}, t.va};
      rem = t.len; first = 1; bs = bsz_of(t.szc);
      while (rem > 0) begin
        if (t.c != 2'd0) begin
          room = bs - int'(a[6:0]);
          ch = (rem < room) ? rem : room;
          b = {a[63:7], 7'b0};
        end else begin
          ch = rem;
          b = a;
        end
        if (!t.ns) begin
          ex[enx] = {a, 14'(ch), (t.bound && (ch == rem)), (t.csum && first), first};
          enx = enx + 1;
        end
        if (t.hwb) begin
          er[enr] = {b, t.stk, t.owner};
          enr = enr + 1;
        end
        a = b + 64'(bs);
        rem = rem - ch;
        first = 0;
      end
    end
    pend_m = pend_m | t.notif;
    if (t.bound) begin
      if (pend_m) enn = enn + 1;
      pend_m = 1'b0;
    end
  endtask

  task automatic send(input tdesc_t t);
    @(posedge clk); #2;
    mem[prod[IDX_W-1:0]] = pack(t, ~prod[IDX_W]);
    prod = prod + 1'b1;
    tail_cnt = prod;
  endtask

  task automatic drain();
    int quiet;
    quiet = 0;
    for (int i = 0; i < 20000 && quiet < 8; i++) begin
      @(negedge clk);
      if (!rd_en && !xc_valid && !rel_valid) quiet = quiet + 1;
      else quiet = 0;
    end
  endtask

  task automatic compare(input string tag);
    chk(nx == enx, {tag, " transfer count"}, nx, enx);
    for (int i = 0; i < nx && i < enx && i < LOGN; i++)
      chk(lx[i] == ex[i], {tag, " transfer fields"}, lx[i], ex[i]);
    chk(nr == enr, {tag, " release count"}, nr, enr);
    for (int i = 0; i < nr && i < enr && i < LOGN; i++)
      chk(lr[i] == er[i], {tag, " release fields"}, lr[i], er[i]);
    chk(nn == enn, {tag, " notif count"}, nn, enn);
    chk(ne == ene, {tag, " error count"}, ne, ene);
  endtask

  task automatic run_one(input tdesc_t t, input string tag);
    clear_logs();
    model(t);
    send(t);
    drain();
    compare(tag);
  endtask

  initial begin
    tdesc_t t;
    n_chk = 0; n_err = 0; cyc = 0;
    prod = '0; pend_m = 1'b0;
    rst_n = 1'b0; tail_cnt = '0; ready_rand = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    clear_logs();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk({xc_valid, rel_valid, rd_en, notif_pulse, desc_err} == 5'b0, "R1 outputs in reset",
        {xc_valid, rel_valid, rd_en, notif_pulse, desc_err}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({xc_valid, rel_valid, rd_en, notif_pulse, desc_err} == 5'b0, "R1 outputs after reset",
        {xc_valid, rel_valid, rd_en, notif_pulse, desc_err}, 0);

    // R2: slot written but tail not moved -> no read
    @(posedge clk); #2;
    t = base_desc();
    mem[0] = pack(t, 1'b1);
    clear_logs();
    repeat (20) @(negedge clk);
    chk(nrd == 0 && nx == 0, "R2 no read while tail equals count", {nrd, nx}, 0);

    // R4 R6 R9 R10 R13: unchained, sign-extended, checksum forwarded
    t = base_desc(); t.csum = 1; t.notif = 1;
    run_one(t, "R4 R6 R9 R10 R13 unchained");
    chk(lcs == {8'h12, 8'h0E, 16'hBEEF}, "R13 checksum fields", lcs, {8'h12, 8'h0E, 16'hBEEF});

    // R5 R6 R9 R12 R3: chained sweep with backpressure, ring wraps repeatedly
    ready_rand = 1'b1;
    for (int code = 0; code < 8; code++) begin
      for (int oi = 0; oi < 3; oi++) begin
        for (int li = 0; li < 4; li++) begin
          int off;
          int bs;
          int l;
          off = (oi == 0) ? 0 : (oi == 1) ? 5 : 127;
          bs = bsz_of(3'(code));
          l = (li == 0) ? 1 : (li == 1) ? bs - off : (li == 2) ? bs - off + 1 : 3 * bs + 7;
          if (l > 16383) l = 16383;
          t = base_desc();
          t.szc = 3'(code); t.c = 2'(1 + (li % 3)); t.len = l;
          t.va = 42'h2AB_CDE0_0000 | 42'(off);
          t.bound = (li != 1); t.notif = (li == 3); t.csum = li[0];
          t.stk = 5'(code + oi);
          run_one(t, "R5 R6 R9 R12 R3 chained sweep");
        end
      end
    end
    ready_rand = 1'b0;

    // R9: no release when hwb clear
    t = base_desc(); t.c = 2'd1; t.szc = 3'd0; t.len = 300; t.hwb = 0;
    run_one(t, "R9 hwb clear");

    // R7: zero length moves nothing
    t = base_desc(); t.len = 0; t.c = 2'd2;
    run_one(t, "R7 zero length");

    // R8: drop descriptor releases buffers only
    t = base_desc(); t.ns = 1; t.c = 2'd1; t.szc = 3'd1; t.len = 700;
    t.va = 42'h000_0040_0010; t.notif = 1;
    run_one(t, "R8 drop chained");

    // R11: reserved bit -> error, no data, boundary notify kept
    t = base_desc(); t.rsvd = 64 + 57; t.notif = 1;
    run_one(t, "R11 reserved word1");
    t = base_desc(); t.rsvd = 13;
    run_one(t, "R11 reserved word0");

    // R10 R6: two-descriptor packet, notify on the first, boundary on the second
    clear_logs();
    t = base_desc(); t.bound = 0; t.notif = 1; t.len = 40;
    model(t); send(t);
    t = base_desc(); t.bound = 1; t.notif = 0; t.len = 60; t.va = 42'h000_1000_0000;
    model(t); send(t);
    drain();
    compare("R10 R6 two-descriptor packet");

    // R3: stale generation is not consumed until rewritten
    clear_logs();
    @(posedge clk); #2;
    t = base_desc();
    mem[prod[IDX_W-1:0]] = pack(t, prod[IDX_W]);
    tail_cnt = prod + 1'b1;
    repeat (40) @(negedge clk);
    chk(nx == 0 && nr == 0 && nrd > 2, "R3 stale slot ignored and re-read", {nx, nr, nrd}, 3);
    @(posedge clk); #2;
    mem[prod[IDX_W-1:0]] = pack(t, ~prod[IDX_W]);
    prod = prod + 1'b1;
    nrd = 0;
    model(t);
    drain();
    compare("R3 refreshed slot");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule